// File: doc/BRIEF.md
# Latency-Hiding Streaming Summation Unit

This unit adds up a stream of signed fixed-point operands. Operands can arrive one per clock with no stalls. The adder inside is pipelined over `LAT` register stages, and its result is fed back as an operand. A single running sum through that adder would create a hazard on every cycle. To avoid it, the unit keeps `LAT` interleaved partial sums and steers each accepted operand to the next one in round-robin order. A slot is never reused before its previous result has come out of the pipeline. A forwarding path hands the emerging result straight back to the adder input.

A run ends when an operand arrives with the end-of-stream flag set. The unit then lets the pipeline empty. It folds the partial sums together one after another through the same adder and presents the total with a one-cycle strobe. The total register is wider than the input operands, so long runs keep their full value. Every new run starts from zero.

Top module: `stream_accum`

## Requirements
- R1: The total equals the two's-complement sum, modulo 2^ACC_W, of all accepted operands. Each operand is sign-extended from IN_W bits. With the defaults ACC_W=40 and IN_W=16, totals far beyond the 16-bit range are kept exactly.
- R2: Whenever `in_valid` is high while a run is open, the operand is accepted in that cycle. Unbroken back-to-back streams are summed without losing any operand.
- R3: Cycles with `in_valid` low add nothing. Idle gaps of any length may separate the operands of a run.
- R4: An operand accepted with `in_last` high closes the run. `out_valid` is high exactly LAT*LAT+2 cycles after the accepting cycle, which is 11 cycles at the default LAT=3.
- R5: `out_valid` is high for exactly one cycle per run.
- R6: `out_data` keeps its value between result strobes.
- R7: `in_valid` is ignored from the cycle after a run closes up to the cycle before its strobe. The strobe cycle already accepts operands for the next run.
- R8: Each run begins from zero, with no carry-over from earlier runs. Runs with fewer operands than LAT give the correct total.
- R9: A synchronous active-low reset clears `out_valid` and `out_data` to 0 and discards any partial run. The next run is summed from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | IN_W | Signed operand |
| in_last | input | 1 | Operand closes the current run |
| out_valid | output | 1 | One-cycle strobe: total is ready |
| out_data | output | ACC_W | Total of the last completed run |

## Verification
The hardest situation to reach from the ports is an operand that meets a slot whose previous sum is leaving the adder in that same cycle. This happens only with unbroken back-to-back input, and only the forwarding path keeps the sum right there. Long streams of random operands with no gaps are therefore driven and compared against a full-width running sum. Streams with random gaps and runs shorter than the slot count exercise untouched slots and skipped forwarding. Random operands are also driven throughout the drain and reduction window, and the total must stay unaffected.

// File: rtl/sa_pkg.sv
// Shared types for the streaming summation unit.
package sa_pkg;
    // Control phases: open run, pipeline drain, partial-sum folding.
    typedef enum logic [1:0] {
        ST_ACC    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_REDUCE = 2'd2
    } sa_state_e;
endpackage

// File: rtl/sa_pipe_adder.sv
// Fixed-point adder pipelined over LAT register stages.
// A tag travels alongside each sum. busy is high while any stage holds a
// valid entry. Assumes LAT >= 2.
module sa_pipe_adder #(
    parameter int DW  = 40,
    parameter int LAT = 3,
    parameter int TW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [TW-1:0] in_tag,
    output logic          out_vld,
    output logic [DW-1:0] out_sum,
    output logic [TW-1:0] out_tag,
    output logic          busy
);
    logic [LAT-1:0] vld_q;
    logic [DW-1:0]  sum_q [LAT];
    logic [TW-1:0]  tag_q [LAT];

    // Valid bits shift with reset so the pipeline starts empty.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAT-2:0], in_vld};
    end

    // Sum formed in the first stage, then carried through the rest.
    always_ff @(posedge clk) begin
        sum_q[0] <= in_a + in_b;
        tag_q[0] <= in_tag;
        for (int i = 1; i < LAT; i++) begin
            sum_q[i] <= sum_q[i-1];
            tag_q[i] <= tag_q[i-1];
        end
    end

    assign out_vld = vld_q[LAT-1];
    assign out_sum = sum_q[LAT-1];
    assign out_tag = tag_q[LAT-1];
    assign busy    = |vld_q;
endmodule

// File: rtl/sa_slot_bank.sv
// Bank of NS partial sums with one write port and two read ports.
// A slot reads as zero until it is claimed in the current run. A read of
// the slot being written this cycle returns the new value (forwarding).
module sa_slot_bank #(
    parameter int DW = 40,
    parameter int NS = 3,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          claim_en,
    input  logic [SW-1:0] claim_idx,
    input  logic          clr_all,
    input  logic [SW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [SW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data
);
    logic [DW-1:0] slot_q [NS];
    logic [NS-1:0] fresh_q;

    // Store sums returning from the adder.
    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_idx] <= wr_data;
    end

    // Track which slots are still zero in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) fresh_q <= '1;
        else if (claim_en)     fresh_q[claim_idx] <= 1'b0;
    end

    // Read port A with zero-fill and forwarding.
    always_comb begin
        if (fresh_q[rd_a_idx])                rd_a_data = '0;
        else if (wr_en && wr_idx == rd_a_idx) rd_a_data = wr_data;
        else                                  rd_a_data = slot_q[rd_a_idx];
    end

    // Read port B with zero-fill and forwarding.
    always_comb begin
        if (fresh_q[rd_b_idx])                rd_b_data = '0;
        else if (wr_en && wr_idx == rd_b_idx) rd_b_data = wr_data;
        else                                  rd_b_data = slot_q[rd_b_idx];
    end
endmodule

// File: rtl/stream_accum.sv
// Streaming summation unit. Accepts one signed operand per cycle into LAT
// round-robin partial sums kept by a LAT-stage adder. After the closing
// operand it waits for the pipeline to empty, then folds the partial sums
// through the same adder and strobes the total.
// Assumes LAT >= 2 and ACC_W > IN_W.
module stream_accum
    import sa_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 40,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data
);
    localparam int SW = $clog2(LAT);
    localparam int TW = SW + 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(LAT - 1);

    sa_state_e        state_q;
    logic [SW-1:0]    slot_q;
    logic [SW-1:0]    fold_q;
    logic [ACC_W-1:0] ext_data;
    logic             iss_vld, claim, finish;
    logic [ACC_W-1:0] iss_a, iss_b;
    logic [TW-1:0]    iss_tag;
    logic             add_vld, add_busy, wr_en;
    logic [ACC_W-1:0] add_sum;
    logic [TW-1:0]    add_tag;
    logic [SW-1:0]    rd_a_idx, rd_b_idx;
    logic [ACC_W-1:0] rd_a_data, rd_b_data;

    assign ext_data = {{(ACC_W - IN_W){in_data[IN_W-1]}}, in_data};
    // Tag MSB marks fold operations, whose results bypass the bank.
    assign wr_en  = add_vld && !add_tag[SW];
    assign finish = (state_q == ST_REDUCE) && add_vld && (fold_q == LAST_SLOT);

    // Choose adder operands and bank read indices for the current phase.
    always_comb begin
        iss_vld  = 1'b0;
        claim    = 1'b0;
        iss_a    = rd_a_data;
        iss_b    = ext_data;
        iss_tag  = {1'b0, slot_q};
        rd_a_idx = slot_q;
        rd_b_idx = fold_q + SW'(1);
        case (state_q)
            ST_ACC: begin
                iss_vld = in_valid;
                claim   = in_valid;
            end
            ST_DRAIN: begin
                rd_a_idx = '0;
                rd_b_idx = SW'(1);
                iss_vld  = !add_busy;
                iss_b    = rd_b_data;
                iss_tag  = {1'b1, {SW{1'b0}}};
            end
            ST_REDUCE: begin
                iss_vld = add_vld && (fold_q != LAST_SLOT);
                iss_a   = add_sum;
                iss_b   = rd_b_data;
                iss_tag = {1'b1, {SW{1'b0}}};
            end
            default: ;
        endcase
    end

    // Phase sequencing, round-robin slot pointer and fold index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACC;
            slot_q  <= '0;
            fold_q  <= '0;
        end else begin
            case (state_q)
                ST_ACC: if (in_valid) begin
                    if (in_last) begin
                        slot_q  <= '0;
                        state_q <= ST_DRAIN;
                    end else begin
                        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + SW'(1);
                    end
                end
                ST_DRAIN: if (!add_busy) begin
                    fold_q  <= SW'(1);
                    state_q <= ST_REDUCE;
                end
                ST_REDUCE: if (add_vld) begin
                    if (fold_q == LAST_SLOT) state_q <= ST_ACC;
                    else                     fold_q  <= fold_q + SW'(1);
                end
                default: state_q <= ST_ACC;
            endcase
        end
    end

    // Result register and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= finish;
            if (finish) out_data <= add_sum;
        end
    end

    sa_pipe_adder #(.DW(ACC_W), .LAT(LAT), .TW(TW)) u_adder (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (iss_vld),
        .in_a    (iss_a),
        .in_b    (iss_b),
        .in_tag  (iss_tag),
        .out_vld (add_vld),
        .out_sum (add_sum),
        .out_tag (add_tag),
        .busy    (add_busy)
    );

    sa_slot_bank #(.DW(ACC_W), .NS(LAT), .SW(SW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (add_tag[SW-1:0]),
        .wr_data   (add_sum),
        .claim_en  (claim),
        .claim_idx (slot_q),
        .clr_all   (finish),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data)
    );
endmodule

// File: rtl/stream_accum_chk.sv
// Port-level checker for stream_accum. An independent counter tracks the
// cycles since a run was closed and checks the strobe timing and the
// stability of the result.
module stream_accum_chk #(
    parameter int ACC_W = 40,
    parameter int LAT   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);
    localparam int LIM = LAT * LAT + 1;
    localparam int CW  = $clog2(LIM + 2) + 1;

    logic          run_q;
    logic [CW-1:0] wait_q;

    // Count cycles from the closing operand to the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wait_q <= '0;
        end else if (out_valid || !run_q) begin
            run_q  <= in_valid && in_last;
            wait_q <= '0;
        end else if (wait_q != CW'(LIM + 1)) begin
            wait_q <= wait_q + CW'(1);
        end
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q && wait_q == CW'(LIM)));

    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && out_data == '0));
endmodule

bind stream_accum stream_accum_chk #(.ACC_W(ACC_W), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/stream_accum_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of short runs, then directed tests.
module stream_accum_bench;
    localparam int IN_W  = 16;
    localparam int ACC_W = 40;
    localparam int LAT   = 3;
    localparam int LATENCY = LAT * LAT + 2;
    localparam longint MASK = (64'sd1 <<< ACC_W) - 1;

    // {last, data} table; five runs.
    localparam logic [IN_W:0] TBL [16] = '{
        {1'b0, 16'd5}, {1'b0, 16'hFFFD}, {1'b1, 16'd100},
        {1'b1, 16'h7FFF},
        {1'b0, 16'hFFFF}, {1'b1, 16'hFFFF},
        {1'b0, 16'h8000}, {1'b0, 16'h8000}, {1'b0, 16'h8000}, {1'b1, 16'h8000},
        {1'b0, 16'd1000}, {1'b0, 16'd2000}, {1'b0, 16'd3000},
        {1'b0, 16'd4000}, {1'b0, 16'd5000}, {1'b1, 16'hE890}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             in_last = 1'b0;
    logic             out_valid;
    logic [ACC_W-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    stream_accum #(.IN_W(IN_W), .ACC_W(ACC_W), .LAT(LAT)) u_stream_accum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sx(input logic [IN_W-1:0] d);
        return longint'($signed(d));
    endfunction

    task automatic send(input logic [IN_W-1:0] d, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // Wait for the strobe after a closing operand; optional junk input.
    task automatic finish_run(input longint exp, input bit junk, input string req);
        int  k = 0;
        bit  seen = 0;
        longint held;
        while (!seen && k < 4 * LATENCY) begin
            @(negedge clk);
            k++;
            if (out_valid) begin
                seen = 1;
                in_valid = 1'b0;
                in_last  = 1'b0;
            end else if (junk) begin
                in_valid = 1'b1;
                in_data  = IN_W'($urandom);
                in_last  = 1'($urandom);
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(seen && k == LATENCY, "R4", "strobe cycle", k, LATENCY);
        check(longint'(out_data) == (exp & MASK), req, "total", longint'(out_data), exp & MASK);
        held = longint'(out_data);
        @(negedge clk);
        check(!out_valid, "R5", "strobe width", longint'(out_valid), 0);
        check(longint'(out_data) == held, "R6", "hold after strobe", longint'(out_data), held);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint acc;
        int     run_len;
        longint held;
        bit     quiet;

        // R9: reset state.
        repeat (4) @(negedge clk);
        check(!out_valid, "R9", "out_valid in reset", longint'(out_valid), 0);
        check(out_data == '0, "R9", "out_data in reset", longint'(out_data), 0);
        rst_n = 1'b1;
        idle(2);

        // Table walk: R1 main sums, R8 short runs and fresh starts.
        acc = 0;
        run_len = 0;
        for (int i = 0; i < 16; i++) begin
            acc += sx(TBL[i][IN_W-1:0]);
            run_len++;
            send(TBL[i][IN_W-1:0], TBL[i][IN_W]);
            if (TBL[i][IN_W]) begin
                finish_run(acc, 1'b0, (run_len < LAT) ? "R8" : "R1");
                acc = 0;
                run_len = 0;
            end
        end

        // R2: long unbroken random stream.
        acc = 0;
        for (int i = 0; i < 3000; i++) begin
            logic [IN_W-1:0] d = IN_W'($urandom);
            acc += sx(d);
            send(d, i == 2999);
        end
        finish_run(acc, 1'b0, "R2");

        // R1: large magnitudes exceed the input width.
        acc = 0;
        for (int i = 0; i < 300; i++) begin
            acc += 32767;
            send(16'h7FFF, i == 299);
        end
        finish_run(acc, 1'b0, "R1");

        // R3: random idle gaps between operands.
        acc = 0;
        for (int i = 0; i < 200; i++) begin
            logic [IN_W-1:0] d = IN_W'($urandom);
            idle(int'($urandom % 4));
            acc += sx(d);
            send(d, i == 199);
        end
        finish_run(acc, 1'b0, "R3");

        // R7: junk driven during drain and folding must be ignored.
        acc = 0;
        for (int i = 0; i < 50; i++) begin
            logic [IN_W-1:0] d = IN_W'($urandom);
            acc += sx(d);
            send(d, i == 49);
        end
        finish_run(acc, 1'b1, "R7");

        // R6: result holds over idle cycles.
        held = longint'(out_data);
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid || longint'(out_data) != held) quiet = 0;
        end
        check(quiet, "R6", "hold over idle", longint'(out_data), held);

        // R9: reset mid-run discards the partial sums.
        send(16'd111, 1'b0);
        send(16'd222, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid, "R9", "out_valid after reset", longint'(out_valid), 0);
        check(out_data == '0, "R9", "out_data after reset", longint'(out_data), 0);
        rst_n = 1'b1;
        idle(1);
        send(16'd7, 1'b0);
        send(16'd9, 1'b1);
        finish_run(16, 1'b0, "R9");

        // R8: single operand right after a run.
        send(16'hFFF0, 1'b1);
        finish_run(-16, 1'b0, "R8");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule